// File: doc/BRIEF.md
# Dot Clock Divider Search Engine

This block picks clock synthesis settings for a requested pixel clock. The target is given in kHz. A PLL multiplier N, an output divider M and a doubler select together set the generated clock. The block runs one sequential search and reports the setting whose frequency is closest to the target without going above it. Monitors tend not to lock to a clock that is too fast, so a result below the target is preferred.

For each divider value, from the largest down to one, the engine builds a base candidate that uses a 3000 kHz reference step. For odd dividers it also builds a doubled candidate that uses a 6000 kHz step. An even divider with the doubled step gives the same frequency as a smaller divider with the base step, so those candidates are skipped. All divisions go through one shared multi-cycle restoring divider, so each candidate takes a few dozen cycles. A start pulse begins the search. The result is held, with `done` high, until the next accepted start.

Top module: `dcs_search`

## Requirements
- R1: The divider M is scanned from 15 down to 1. For each M the base candidate is tried before the doubled one. A candidate replaces the current best only when its shortfall is strictly smaller, so on a tie the earlier candidate is kept.
- R2: The base candidate is N = floor(M*T/3000) and its achieved frequency is floor(3000*N/M) kHz, where T is the target.
- R3: The doubled candidate uses a 6000 kHz step in the same formulas. It is tried only for odd M. `best_dbl` is 1 when the chosen candidate is a doubled one.
- R4: A candidate is valid only if N lies between 9 and 127 inclusive.
- R5: The result is the valid candidate with the smallest shortfall T minus achieved. `achieved_khz` is never above the target.
- R6: When no candidate is valid, the search ends with `done`=1, `no_match`=1, and `best_n`, `best_m`, `best_dbl` and `achieved_khz` all 0.
- R7: `done` rises when the search ends and stays high until a new start is accepted. It is low in the cycle after that start.
- R8: A start pulse that arrives while a search is running is ignored, and the running search finishes on its own target.
- R9: After reset, `done` and `no_match` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a search when idle |
| target_khz | input | TW (20) | Requested pixel clock in kHz, sampled at start |
| best_n | output | NW (7) | Chosen PLL multiplier |
| best_m | output | MW (4) | Chosen output divider |
| best_dbl | output | 1 | 1 selects the doubled (6000 kHz) step |
| achieved_khz | output | TW (20) | Frequency given by the chosen setting |
| done | output | 1 | Search finished, result valid |
| no_match | output | 1 | Search finished with no valid candidate |

## Verification
The targets cover several common display rates. Some divide exactly and must give zero shortfall at the highest divider; others must settle on a doubled candidate at an odd divider. The 1800 and 1799 kHz targets fall on either side of the lower N bound and tell apart a correct range check from an off-by-one. Targets above 384 MHz are reachable only through the doubled step, and a target above 768 MHz has no valid candidate at all, which exercises the no-match path. A start pulse sent mid-search and a restart after completion check that busy starts are ignored and that `done` clears.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NDIV = 2'd1,
        ST_VDIV = 2'd2
    } dcs_state_e;

    localparam int STEP_BASE = 3000;
    localparam int STEP_DBL  = 6000;
    localparam int N_MIN     = 9;
    localparam int DIFF_W    = 28;
    localparam logic [DIFF_W-1:0] DIFF_SENTINEL = 28'h0FFFFFFF;
endpackage

// File: rtl/dcs_divider.sv
module dcs_divider #(
    parameter int W    = 24,
    parameter int DENW = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [W-1:0]    num,
    input  logic [DENW-1:0] den,
    output logic [W-1:0]    quo,
    output logic            fin
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [DENW-1:0] rem;
        logic [DENW-1:0] den;
        logic [W-1:0]    sh;
        logic            fin;
    } div_t;

    div_t q, d;
    logic [DENW:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem, q.sh[W-1]};
        if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(W);
            d.rem  = '0;
            d.den  = den;
            d.sh   = num;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DENW'(trial - {1'b0, q.den});
                d.sh  = {q.sh[W-2:0], 1'b1};
            end else begin
                d.rem = trial[DENW-1:0];
                d.sh  = {q.sh[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo = q.sh;
    assign fin = q.fin;

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.den != '0) |-> (q.rem < q.den)); // R2
endmodule

// File: rtl/dcs_best.sv
module dcs_best #(
    parameter int TW = 20,
    parameter int MW = 4,
    parameter int NW = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      offer,
    input  logic [dcs_pkg::DIFF_W-1:0] cand_diff,
    input  logic [NW-1:0]             cand_n,
    input  logic [MW-1:0]             cand_m,
    input  logic                      cand_dbl,
    input  logic [TW-1:0]             cand_val,
    output logic [NW-1:0]             best_n,
    output logic [MW-1:0]             best_m,
    output logic                      best_dbl,
    output logic [TW-1:0]             best_val
);
    import dcs_pkg::*;

    typedef struct packed {
        logic [DIFF_W-1:0] diff;
        logic [NW-1:0]     n;
        logic [MW-1:0]     m;
        logic              dbl;
        logic [TW-1:0]     val;
    } best_t;

    best_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d      = '0;
            d.diff = DIFF_SENTINEL;
        end else if (offer && cand_diff < q.diff) begin
            d.diff = cand_diff;
            d.n    = cand_n;
            d.m    = cand_m;
            d.dbl  = cand_dbl;
            d.val  = cand_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.diff <= DIFF_SENTINEL;
        end else begin
            q <= d;
        end
    end

    assign best_n   = q.n;
    assign best_m   = q.m;
    assign best_dbl = q.dbl;
    assign best_val = q.val;

    AST_DIFF_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && offer) |=> (q.diff <= $past(q.diff))); // R1
endmodule

// File: rtl/dcs_search.sv
module dcs_search #(
    parameter int TW = 20,
    parameter int MW = 4,
    parameter int NW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] target_khz,
    output logic [NW-1:0] best_n,
    output logic [MW-1:0] best_m,
    output logic          best_dbl,
    output logic [TW-1:0] achieved_khz,
    output logic          done,
    output logic          no_match
);
    import dcs_pkg::*;

    localparam int W    = TW + MW;
    localparam int DENW = $clog2(STEP_DBL + 1);
    localparam int M_TOP = (1 << MW) - 1;
    localparam int N_MAX = (1 << NW) - 1;

    typedef struct packed {
        dcs_state_e      st;
        logic [MW-1:0]   m;
        logic            dbl;
        logic [NW-1:0]   n;
        logic [TW-1:0]   tgt;
        logic            go;
        logic [W-1:0]    num;
        logic [DENW-1:0] den;
        logic            done;
    } ctl_t;

    ctl_t q, d;

    logic [W-1:0]       div_q;
    logic               div_fin;
    logic               clr, offer, adv;
    logic [DIFF_W-1:0]  cand_diff;
    logic [MW-1:0]      m_dec;

    dcs_divider #(.W(W), .DENW(DENW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.go),
        .num  (q.num),
        .den  (q.den),
        .quo  (div_q),
        .fin  (div_fin)
    );

    assign cand_diff = DIFF_W'(q.tgt) - DIFF_W'(div_q[TW-1:0]);
    assign m_dec     = q.m - 1'b1;

    always_comb begin
        d     = q;
        d.go  = 1'b0;
        clr   = 1'b0;
        offer = 1'b0;
        adv   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.tgt  = target_khz;
                    d.m    = MW'(M_TOP);
                    d.dbl  = 1'b0;
                    d.done = 1'b0;
                    clr    = 1'b1;
                    d.go   = 1'b1;
                    d.num  = W'(M_TOP) * W'(target_khz);
                    d.den  = DENW'(STEP_BASE);
                    d.st   = ST_NDIV;
                end
            end
            ST_NDIV: begin
                if (div_fin) begin
                    if (div_q >= W'(N_MIN) && div_q <= W'(N_MAX)) begin
                        d.n   = div_q[NW-1:0];
                        d.go  = 1'b1;
                        d.num = W'(q.dbl ? STEP_DBL : STEP_BASE) * W'(div_q[NW-1:0]);
                        d.den = DENW'(q.m);
                        d.st  = ST_VDIV;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            ST_VDIV: begin
                if (div_fin) begin
                    offer = 1'b1;
                    adv   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (adv) begin
            if (!q.dbl && q.m[0]) begin
                d.dbl = 1'b1;
                d.go  = 1'b1;
                d.num = W'(q.m) * W'(q.tgt);
                d.den = DENW'(STEP_DBL);
                d.st  = ST_NDIV;
            end else if (q.m == MW'(1)) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.m   = m_dec;
                d.dbl = 1'b0;
                d.go  = 1'b1;
                d.num = W'(m_dec) * W'(q.tgt);
                d.den = DENW'(STEP_BASE);
                d.st  = ST_NDIV;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    dcs_best #(.TW(TW), .MW(MW), .NW(NW)) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr),
        .offer    (offer),
        .cand_diff(cand_diff),
        .cand_n   (q.n),
        .cand_m   (q.m),
        .cand_dbl (q.dbl),
        .cand_val (div_q[TW-1:0]),
        .best_n   (best_n),
        .best_m   (best_m),
        .best_dbl (best_dbl),
        .best_val (achieved_khz)
    );

    assign done     = q.done;
    assign no_match = q.done && (best_m == '0);

    AST_ACH_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (achieved_khz <= q.tgt)); // R5
    AST_N_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_match) |-> (best_n >= NW'(N_MIN))); // R4
    AST_DBL_ODD_M: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_dbl) |-> best_m[0]); // R3
    AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_match) |-> (best_n == '0 && !best_dbl && achieved_khz == '0)); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start) |=> !done); // R7
    AST_BUSY_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start) |=> $stable(q.tgt)); // R8
endmodule

// File: tb/sim_dcs_search.sv
module sim_dcs_search;
    localparam int TW = 20;
    localparam int MW = 4;
    localparam int NW = 7;
    localparam int NV = 12;
    localparam int unsigned TGT [NV] = '{25175, 65000, 148500, 27000, 74250, 108000,
                                         383999, 500000, 3000, 1800, 1799, 800000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] target_khz = '0;
    logic [NW-1:0] best_n;
    logic [MW-1:0] best_m;
    logic          best_dbl;
    logic [TW-1:0] achieved_khz;
    logic          done;
    logic          no_match;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dcs_search #(.TW(TW), .MW(MW), .NW(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .best_n(best_n), .best_m(best_m), .best_dbl(best_dbl),
        .achieved_khz(achieved_khz), .done(done), .no_match(no_match)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference built from the requirements
    task automatic model(input int t, output int en, output int em, output int ed, output int ea);
        int bd;
        bd = 32'h0FFFFFFF; en = 0; em = 0; ed = 0; ea = 0;
        for (int m = 15; m >= 1; m--) begin
            for (int k = 0; k < 2; k++) begin
                int step, n, v;
                if (k == 1 && (m % 2) == 0) continue;
                step = (k == 1) ? 6000 : 3000;
                n = (m * t) / step;
                if (n >= 9 && n <= 127) begin
                    v = (step * n) / m;
                    if (t - v < bd) begin
                        bd = t - v; en = n; em = m; ed = k; ea = v;
                    end
                end
            end
        end
    endtask

    task automatic run(input int t);
        int wd;
        @(negedge clk);
        target_khz = TW'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 20000) chk("R7 watchdog", 0, 1);
    endtask

    task automatic compare(input int t, input string tag);
        int en, em, ed, ea;
        model(t, en, em, ed, ea);
        chk({tag, " R2 n"}, int'(best_n), en);
        chk({tag, " R1 m"}, int'(best_m), em);
        chk({tag, " R3 dbl"}, int'(best_dbl), ed);
        chk({tag, " R5 achieved"}, int'(achieved_khz), ea);
        chk({tag, " R6 no_match"}, int'(no_match), (em == 0) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 done", int'(done), 0);
        chk("R9 no_match", int'(no_match), 0);
        chk("R9 n", int'(best_n), 0);
        chk("R9 achieved", int'(achieved_khz), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(int'(TGT[i]));
            chk("R7 done", int'(done), 1);
            compare(int'(TGT[i]), "vec");
        end

        // R1 tie: 3000 exact at M=15 must stay there
        run(3000);
        chk("R1 tie m", int'(best_m), 15);
        chk("R1 tie n", int'(best_n), 15);
        // R4 lower bound edge: N=9 valid, 1799 gives none
        run(1800);
        chk("R4 n=9", int'(best_n), 9);
        run(1799);
        chk("R6 nomatch", int'(no_match), 1);
        chk("R6 m zero", int'(best_m), 0);
        // R3 only doubled step reaches 500000 at M=1
        run(500000);
        chk("R3 dbl", int'(best_dbl), 1);
        chk("R3 n", int'(best_n), 83);

        // R7 done clears after new start
        @(negedge clk);
        target_khz = TW'(65000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 done low", int'(done), 0);
        // R8 start during search ignored
        repeat (5) @(negedge clk);
        target_khz = TW'(1799);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int wd = 0;
            while (!done && wd < 20000) begin
                @(negedge clk);
                wd++;
            end
            if (wd >= 20000) chk("R8 watchdog", 0, 1);
        end
        compare(65000, "R8 busy");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 global watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule